// File: doc/BRIEF.md
# Output Readback Mismatch Monitor

This block checks, for four output channels, that the level each pin is told to drive is the level that is actually sampled back from the pad. The channels are an interrupt-request output (channel 0), a driver-enable output (channel 1) and two reset outputs (channels 2 and 3). Each channel presents a commanded level, an asynchronous pad sample and a 3-bit function-select code. The driver-enable channel is checked at both levels. The other three channels are checked only while they drive low, so an external pull-down on those nets is tolerated.

Comparison runs every cycle with no filter, so one bad sample is enough. After the commanded level of a channel toggles, or after its function-select code changes, checking on that channel is blanked for a fixed number of cycles. Each disagreement sets a sticky per-channel status bit. Software clears the bit with a write-1-to-clear strobe. A single interrupt line combines all status bits after a per-channel mask.

Top module: `readback_monitor`

## Requirements
- R1: After reset, all status bits and the combined interrupt are 0, and checking on every channel is blanked for GATE_CYCLES (default 16) cycles.
- R2: Channel 1 (driver enable) sets its status bit when the synchronized pad level differs from the commanded level, whether the commanded level is high or low.
- R3: Channels 0, 2 and 3 set their status bit only when the commanded level is 0 and the pad reads 1. A pad reading 0 while the commanded level is 1 is ignored.
- R4: The pad input passes through two flops and the commanded level is delayed by two cycles before comparison. A pad that differs from a steady commanded level sets the status bit at the third rising edge after the change.
- R5: No filtering is applied: a pad disagreement present for a single clock sample sets the status bit once blanking is over.
- R6: A change of a channel's commanded level reloads that channel's blanking counter to the full GATE_CYCLES, including a change that occurs while blanking is still active.
- R7: A change of a channel's 3-bit function-select value also reloads that channel's blanking counter to GATE_CYCLES.
- R8: A channel is checked only while its enable input is 1 and its function-select equals its assigned code (default: channel 0 = 1, channel 1 = 2, channel 2 = 3, channel 3 = 4). Channel i uses func_sel bits [3i+2:3i].
- R9: Status bits hold until cleared by a 1 on the matching clear strobe bit. If a mismatch is detected in the same cycle as a clear, the bit stays set.
- R10: The interrupt output is 1 exactly when some status bit is 1 and its mask bit is 1. The output is combinational from the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_lvl | input | 4 | Commanded level per channel |
| pad_lvl | input | 4 | Asynchronous pad readback per channel |
| func_sel | input | 12 | 3-bit function-select code per channel |
| chan_en | input | 4 | Per-channel check enable |
| clr_w1c | input | 4 | Write-1-to-clear strobe per status bit |
| irq_mask | input | 4 | Per-channel interrupt mask, 1 passes the bit |
| status | output | 4 | Sticky mismatch flags |
| irq | output | 1 | Masked OR of the status bits |

## Verification
A blanking counter that stops too early or is not reloaded shows at the ports as a status bit that rises in the cycles just after a toggle or a select change. A counter that is stuck shows as a bit that never rises. A synchronizer or delay line with the wrong length moves the rising edge of a status bit by one or more cycles, or produces a false flag right after a normal level change. Because the bench compares every status bit and the interrupt line with a cycle-accurate model on every clock, each of these faults is reported in the first cycle in which the output differs.

// File: rtl/readback_monitor.sv
module readback_monitor #(
  parameter int NCH         = 4,
  parameter int SEL_W       = 3,
  parameter int GATE_CYCLES = 16,
  parameter logic [NCH-1:0]       BOTH_LEVELS = 4'b0010,
  parameter logic [NCH*SEL_W-1:0] FUNC_CODES  = {3'd4, 3'd3, 3'd2, 3'd1}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cmd_lvl,
  input  logic [NCH-1:0]       pad_lvl,
  input  logic [NCH*SEL_W-1:0] func_sel,
  input  logic [NCH-1:0]       chan_en,
  input  logic [NCH-1:0]       clr_w1c,
  input  logic [NCH-1:0]       irq_mask,
  output logic [NCH-1:0]       status,
  output logic                 irq
);
  localparam int GW = $clog2(GATE_CYCLES + 1);
  localparam logic [GW-1:0] GATE_LOAD = GW'(GATE_CYCLES);

  logic [NCH-1:0]         pad_s1, pad_s2, cmd_d1, cmd_d2;
  logic [NCH*SEL_W-1:0]   sel_q;
  logic [NCH-1:0][GW-1:0] gate_cnt;
  logic [NCH-1:0]         sel_chg, sel_hit, gate_open, level_err, mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_s1 <= '0;
      pad_s2 <= '0;
      cmd_d1 <= '0;
      cmd_d2 <= '0;
      sel_q  <= '0;
      status <= '0;
    end else begin
      pad_s1 <= pad_lvl;
      pad_s2 <= pad_s1;
      cmd_d1 <= cmd_lvl;
      cmd_d2 <= cmd_d1;
      sel_q  <= func_sel;
      status <= (status & ~clr_w1c) | mismatch;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign sel_chg[i]   = func_sel[i*SEL_W +: SEL_W] != sel_q[i*SEL_W +: SEL_W];
    assign sel_hit[i]   = func_sel[i*SEL_W +: SEL_W] == FUNC_CODES[i*SEL_W +: SEL_W];
    assign gate_open[i] = gate_cnt[i] == '0;

    if (BOTH_LEVELS[i]) begin : g_both
      assign level_err[i] = cmd_d2[i] ^ pad_s2[i];
    end else begin : g_low
      assign level_err[i] = ~cmd_d2[i] & pad_s2[i];
    end

    assign mismatch[i] = chan_en[i] & sel_hit[i] & gate_open[i] & ~sel_chg[i] & level_err[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gate_cnt[i] <= GATE_LOAD;
      else if ((cmd_lvl[i] != cmd_d1[i]) || sel_chg[i])
        gate_cnt[i] <= GATE_LOAD;
      else if (!gate_open[i])
        gate_cnt[i] <= gate_cnt[i] - 1'b1;
    end
  end

  assign irq = |(status & irq_mask);
endmodule

module readback_monitor_chk #(
  parameter int NCH         = 4,
  parameter int GW          = 5,
  parameter int GATE_CYCLES = 16,
  parameter logic [NCH-1:0] BOTH_LEVELS = 4'b0010
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       cmd_lvl,
  input logic [NCH-1:0]       cmd_d1,
  input logic [NCH-1:0]       cmd_d2,
  input logic [NCH-1:0]       chan_en,
  input logic [NCH-1:0]       clr_w1c,
  input logic [NCH-1:0]       irq_mask,
  input logic [NCH-1:0][GW-1:0] gate_cnt,
  input logic [NCH-1:0]       status,
  input logic                 irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_no_set_while_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(gate_cnt[i] == '0));
    assert_toggle_reloads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_lvl[i] != cmd_d1[i]) |=> (gate_cnt[i] == GW'(GATE_CYCLES)));
    assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[i]) |-> $past(chan_en[i]));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr_w1c[i]) |=> status[i]);
    if (!BOTH_LEVELS[i]) begin : g_low
      assert_low_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[i]) |-> $past(cmd_d2[i] == 1'b0));
    end
  end

  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);
  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind readback_monitor readback_monitor_chk #(
  .NCH(NCH), .GW(GW), .GATE_CYCLES(GATE_CYCLES), .BOTH_LEVELS(BOTH_LEVELS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_lvl(cmd_lvl), .cmd_d1(cmd_d1), .cmd_d2(cmd_d2),
  .chan_en(chan_en), .clr_w1c(clr_w1c), .irq_mask(irq_mask), .gate_cnt(gate_cnt),
  .status(status), .irq(irq)
);

// File: tb/test_readback_monitor.sv
module test_readback_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int G = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  cmd_lvl = 4'hF, pad_lvl = 4'hF, chan_en = 4'hF, clr_w1c = 4'h0, irq_mask = 4'hF;
  logic [11:0] func_sel = {3'd4, 3'd3, 3'd2, 3'd1};
  logic [3:0]  status;
  logic        irq;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  readback_monitor i_readback_monitor (
    .clk(clk), .rst_n(rst_n), .cmd_lvl(cmd_lvl), .pad_lvl(pad_lvl), .func_sel(func_sel),
    .chan_en(chan_en), .clr_w1c(clr_w1c), .irq_mask(irq_mask), .status(status), .irq(irq)
  );

  // behavioural reference model
  int m_gate[4];
  int m_cmd_hist[4][$];
  int m_pad_hist[4][$];
  int m_sel[4];
  bit [3:0] m_stat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0;
      for (int i = 0; i < 4; i++) begin
        m_gate[i] = G;
        m_sel[i] = 0;
        m_cmd_hist[i] = '{0, 0};
        m_pad_hist[i] = '{0, 0};
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int sel_now, cmd_old2, pad_old2;
        bit toggled, sel_changed, err, hit;
        sel_now     = int'(func_sel[i*3 +: 3]);
        cmd_old2    = m_cmd_hist[i][0];
        pad_old2    = m_pad_hist[i][0];
        toggled     = int'(cmd_lvl[i]) != m_cmd_hist[i][1];
        sel_changed = sel_now != m_sel[i];
        if (i == 1) err = cmd_old2 != pad_old2;
        else        err = (cmd_old2 == 0) && (pad_old2 == 1);
        hit = chan_en[i] && (sel_now == i + 1) && (m_gate[i] == 0) && !sel_changed && err;
        if (clr_w1c[i]) m_stat[i] = 1'b0;
        if (hit) m_stat[i] = 1'b1;
        if (toggled || sel_changed) m_gate[i] = G;
        else if (m_gate[i] > 0)     m_gate[i] = m_gate[i] - 1;
        void'(m_cmd_hist[i].pop_front());
        m_cmd_hist[i].push_back(int'(cmd_lvl[i]));
        void'(m_pad_hist[i].pop_front());
        m_pad_hist[i].push_back(int'(pad_lvl[i]));
        m_sel[i] = sel_now;
      end
    end
  end

  task automatic compare();
    bit exp_irq;
    exp_irq = |(m_stat & irq_mask);
    vectors++;
    if (status !== m_stat || irq !== exp_irq) begin
      errors++;
      $display("FAIL %s cycle %0d: status=%b irq=%b expected status=%b irq=%b",
               cur_req, cycles, status, irq, m_stat, exp_irq);
    end
  endtask

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cycles++;
      compare();
    end
  endtask

  task automatic expect_state(logic [3:0] exp_s, logic exp_i, string req);
    vectors++;
    if (status !== exp_s || irq !== exp_i) begin
      errors++;
      $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b", req, status, irq, exp_s, exp_i);
    end
  endtask

  task automatic clear(logic [3:0] bits);
    clr_w1c = bits;
    tick(1);
    clr_w1c = '0;
    tick(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_state(4'b0000, 1'b0, "R1");
    rst_n = 1'b1;
    cur_req = "R1"; tick(25);
    expect_state(4'b0000, 1'b0, "R1");

    cur_req = "R3"; pad_lvl[0] = 1'b0; tick(25);
    expect_state(4'b0000, 1'b0, "R3 pulled low tolerated");
    pad_lvl[0] = 1'b1; cmd_lvl[0] = 1'b0;
    cur_req = "R6"; tick(10);
    expect_state(4'b0000, 1'b0, "R6 blanking after toggle");
    cur_req = "R3"; tick(15);
    expect_state(4'b0001, 1'b1, "R3 low-driven mismatch");

    cur_req = "R9"; clear(4'b0001);
    expect_state(4'b0001, 1'b1, "R9 set wins over clear");
    cmd_lvl[0] = 1'b1; tick(4); clear(4'b0001);
    expect_state(4'b0000, 1'b0, "R9 cleared");

    cur_req = "R4"; pad_lvl[1] = 1'b0;
    tick(2);
    expect_state(4'b0000, 1'b0, "R4 two-cycle sync");
    tick(1);
    expect_state(4'b0010, 1'b1, "R4 set at third edge");
    cur_req = "R2"; pad_lvl[1] = 1'b1; tick(4); clear(4'b0010);
    cmd_lvl[1] = 1'b0; tick(25);
    expect_state(4'b0010, 1'b1, "R2 high pad while low commanded");
    pad_lvl[1] = 1'b0; tick(4); clear(4'b0010);
    cmd_lvl[1] = 1'b1; pad_lvl[1] = 1'b1; tick(25);
    expect_state(4'b0000, 1'b0, "R2 normal toggle no flag");

    cur_req = "R5"; cmd_lvl[2] = 1'b0; pad_lvl[2] = 1'b0; tick(25);
    pad_lvl[2] = 1'b1; tick(1); pad_lvl[2] = 1'b0; tick(5);
    expect_state(4'b0100, 1'b1, "R5 single sample");
    clear(4'b0100);

    cur_req = "R8"; chan_en[3] = 1'b0; cmd_lvl[3] = 1'b0; tick(25);
    expect_state(4'b0000, 1'b0, "R8 disabled channel");
    chan_en[3] = 1'b1; tick(5);
    expect_state(4'b1000, 1'b1, "R8 enabled channel");
    cmd_lvl[3] = 1'b1; tick(4); clear(4'b1000);
    func_sel[11:9] = 3'd7; cmd_lvl[3] = 1'b0; tick(25);
    expect_state(4'b0000, 1'b0, "R8 wrong select code");
    cur_req = "R7"; func_sel[11:9] = 3'd4; tick(10);
    expect_state(4'b0000, 1'b0, "R7 blanking after select change");
    tick(15);
    expect_state(4'b1000, 1'b1, "R7 checking resumes");
    cmd_lvl[3] = 1'b1; tick(4); clear(4'b1000);

    cur_req = "R6"; cmd_lvl[0] = 1'b0; tick(10);
    cmd_lvl[0] = 1'b1; tick(1); cmd_lvl[0] = 1'b0; tick(12);
    expect_state(4'b0000, 1'b0, "R6 reload on retoggle");
    tick(10);
    expect_state(4'b0001, 1'b1, "R6 flag after reloaded window");

    cur_req = "R10"; irq_mask = 4'b1110; tick(2);
    expect_state(4'b0001, 1'b0, "R10 masked");
    irq_mask = 4'b1111; tick(1);
    expect_state(4'b0001, 1'b1, "R10 unmasked");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule